// File: doc/BRIEF.md
# Oversampled Serial Receiver with Character Queue

This block receives one asynchronous serial channel. It watches the incoming line on a 16x bit-rate enable and assembles characters of five to eight data bits. An optional ninth bit follows the data bits and is used either as parity or as an address/data marker. Characters that are accepted wait in a three-entry queue. A completed character that finds the queue full waits in a single holding slot. The CPU therefore sees up to four characters of buffering before anything is lost.

The CPU takes the oldest character by pulsing a read strobe. Status outputs describe queue occupancy, overrun, parity, framing, break and address marking. The error flags either follow the oldest queued character or collect across many characters until a clear strobe. An optional flow-control output drops when the queue fills. A multi-drop setting lets address characters through while normal reception is switched off.

Top module: `rx_serial_fifo`

## Requirements
- R1: After a high-to-low transition of `rxd` seen on an `os_tick`, the line is checked again 7 ticks later and each following bit is taken every 16 ticks, LSB first. `len_sel` values 0,1,2,3 select 5,6,7,8 data bits. Unused upper bits of `rd_data` read 0.
- R2: If the line is high at the 7-tick recheck, the start is discarded, no character is produced, and hunting resumes.
- R3: Accepted characters are returned in arrival order, up to four held at once. `rx_rdy` means at least one character is queued. `fifo_full` means three are queued. A read strobe while empty has no effect.
- R4: A character that completes while the queue holds three and the holding slot is occupied sets `ovr_err` and is dropped, while the four held characters remain. `err_clr` clears `ovr_err`.
- R5: With `par_en`=1 and `mdrop_en`=0, a ninth bit follows the data. `par_odd`=0 requires an even count of ones over data plus that bit, and `par_odd`=1 requires an odd count. A mismatch marks `par_err`.
- R6: A stop position sampled low on a character that is not all zeros marks `frm_err`.
- R7: With `blk_err_mode`=0, `par_err`, `frm_err` and `brk_flag` describe only the oldest queued character. With `blk_err_mode`=1 they are the OR over every character queued since the last `err_clr` and survive reads.
- R8: A character whose data, ninth bit and stop position are all low queues a zero with `brk_flag` set. `brk_delta` pulses for one cycle then, and again when the line returns high. No start is hunted before that return.
- R9: With `rts_auto`=1, `rts_o` goes low while three characters are queued and returns high once fewer are queued. With `rts_auto`=0 it stays high.
- R10: With `mdrop_en`=1, the ninth bit is stored as `addr_flag` (1 = address) and parity is not checked. While `rx_en`=0, only characters with that bit at 1 are queued.
- R11: While `rx_en`=0 and `mdrop_en`=0, completed characters are not queued.
- R12: After reset `rx_rdy`, `fifo_full`, `ovr_err`, all error flags and `rd_data` are 0, and `rts_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| os_tick | input | 1 | 16x bit-rate enable |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Normal reception enable |
| len_sel | input | 2 | Data bits: 0..3 = 5..8 |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| mdrop_en | input | 1 | Ninth bit is an address marker |
| blk_err_mode | input | 1 | 1 = accumulate error flags |
| rts_auto | input | 1 | Enable flow-control drop on full |
| rd_pop | input | 1 | Remove the oldest character |
| err_clr | input | 1 | Clear overrun and accumulated errors |
| rd_data | output | 8 | Oldest character |
| rx_rdy | output | 1 | Queue not empty |
| fifo_full | output | 1 | Queue holds three characters |
| ovr_err | output | 1 | Character lost to overrun |
| par_err | output | 1 | Parity error flag |
| frm_err | output | 1 | Framing error flag |
| brk_flag | output | 1 | Break flag |
| addr_flag | output | 1 | Oldest character is an address |
| brk_delta | output | 1 | Pulse at break start and end |
| rts_o | output | 1 | Flow-control output, high = ready |

## Verification
A wrong sampling phase shows at the ports within one character time, as a shifted or corrupted `rd_data` or a spurious `frm_err`. A broken queue pointer or holding slot appears as data out of order or a lost character after the fourth read. It can also appear as an `ovr_err` that comes one character too early or too late. Errors in the error-mode or flow-control logic show on the first read after the affected character, when a flag persists or vanishes against the selected mode, or when `rts_o` disagrees with the queue level.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              addr;
    logic              brk;
    logic              fe;
    logic              pe;
    logic [DATA_W-1:0] data;
  } rx_char_t;

  localparam int CHAR_W = $bits(rx_char_t);
endpackage

// File: rtl/rx_bit_engine.sv
module rx_bit_engine
  import rxq_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] len_sel,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       mdrop_en,
  output logic       done,
  output rx_char_t   chr,
  output logic       brk_evt
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID_LAST = CW'(OSR/2 - 2);
  localparam logic [CW-1:0] BIT_LAST = CW'(OSR - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_BRK} st_t;

  st_t             st;
  logic            s1, line, prev;
  logic [CW-1:0]   tcnt;
  logic [3:0]      bidx;
  logic [8:0]      sh;
  logic [3:0]      nd, last;
  logic            has_x;
  logic [8:0]      al, xsh;
  logic [7:0]      dmask, data_c;
  logic            xb_c, zero_c;

  always_comb begin
    nd     = 4'd5 + {2'b00, len_sel};
    has_x  = par_en | mdrop_en;
    last   = nd + {3'b000, has_x};
    al     = sh >> (4'd9 - last);
    dmask  = 8'hFF >> (4'd8 - nd);
    data_c = al[7:0] & dmask;
    xsh    = al >> nd;
    xb_c   = has_x & xsh[0];
    zero_c = (al == 9'd0) && !line;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1; line <= 1'b1; prev <= 1'b1;
      st <= S_IDLE; tcnt <= '0; bidx <= '0; sh <= '0;
      done <= 1'b0; brk_evt <= 1'b0; chr <= '0;
    end else begin
      s1      <= rxd;
      line    <= s1;
      done    <= 1'b0;
      brk_evt <= 1'b0;
      if (tick) begin
        prev <= line;
        case (st)
          S_IDLE: if (prev && !line) begin
            st <= S_START; tcnt <= '0;
          end
          S_START: begin
            if (tcnt == MID_LAST) begin
              tcnt <= '0; bidx <= '0; sh <= '0;
              st   <= line ? S_IDLE : S_BITS;
            end else tcnt <= tcnt + 1'b1;
          end
          S_BITS: begin
            if (tcnt == BIT_LAST) begin
              tcnt <= '0;
              if (bidx == last) begin
                done      <= 1'b1;
                chr.data  <= data_c;
                chr.brk   <= zero_c;
                chr.fe    <= !line && !zero_c;
                chr.pe    <= par_en && !mdrop_en && !zero_c &&
                             ((^data_c ^ xb_c) != par_odd);
                chr.addr  <= mdrop_en && xb_c;
                if (zero_c) begin
                  brk_evt <= 1'b1; st <= S_BRK;
                end else st <= S_IDLE;
              end else begin
                sh   <= {line, sh[8:1]};
                bidx <= bidx + 1'b1;
              end
            end else tcnt <= tcnt + 1'b1;
          end
          S_BRK: if (line) begin
            brk_evt <= 1'b1; st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_brk_evt_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    brk_evt |=> !brk_evt);
  p_brk_no_fe_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !(chr.brk && chr.fe));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int DEPTH = 3,
  parameter int W     = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          push,
  input  logic [W-1:0]                  din,
  input  logic                          pop,
  output logic [W-1:0]                  dout,
  output logic [$clog2(DEPTH+1)-1:0]    count
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH+1);
  localparam logic [AW-1:0]   P_LAST = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] C_FULL = CNTW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else begin
      if (push) wptr <= (wptr == P_LAST) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == P_LAST) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout = mem[rptr];

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    push |-> (count != C_FULL));
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
endmodule

// File: rtl/rx_flags.sv
module rx_flags
  import rxq_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(DEPTH+1)-1:0]  cnt,
  input  rx_char_t                    top,
  input  logic                        push,
  input  rx_char_t                    push_chr,
  input  logic                        ovr_evt,
  input  logic                        brk_evt,
  input  logic                        err_clr,
  input  logic                        blk_err_mode,
  input  logic                        rts_auto,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        rx_rdy,
  output logic                        fifo_full,
  output logic                        ovr_err,
  output logic                        par_err,
  output logic                        frm_err,
  output logic                        brk_flag,
  output logic                        addr_flag,
  output logic                        brk_delta,
  output logic                        rts_o
);
  localparam int CNTW = $clog2(DEPTH+1);
  localparam logic [CNTW-1:0] C_FULL = CNTW'(DEPTH);

  logic acc_pe, acc_fe, acc_brk, nonempty, is_full;

  assign nonempty = (cnt != '0);
  assign is_full  = (cnt == C_FULL);

  always_ff @(posedge clk) begin
    if (rst || err_clr) begin
      acc_pe <= 1'b0; acc_fe <= 1'b0; acc_brk <= 1'b0;
    end else if (push) begin
      acc_pe  <= acc_pe  | push_chr.pe;
      acc_fe  <= acc_fe  | push_chr.fe;
      acc_brk <= acc_brk | push_chr.brk;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0; rx_rdy <= 1'b0; fifo_full <= 1'b0; ovr_err <= 1'b0;
      par_err <= 1'b0; frm_err <= 1'b0; brk_flag <= 1'b0;
      addr_flag <= 1'b0; brk_delta <= 1'b0; rts_o <= 1'b1;
    end else begin
      rd_data   <= nonempty ? top.data : '0;
      rx_rdy    <= nonempty;
      fifo_full <= is_full;
      addr_flag <= nonempty & top.addr;
      brk_delta <= brk_evt;
      rts_o     <= !(rts_auto && is_full);
      if (ovr_evt)      ovr_err <= 1'b1;
      else if (err_clr) ovr_err <= 1'b0;
      if (blk_err_mode) begin
        par_err <= acc_pe; frm_err <= acc_fe; brk_flag <= acc_brk;
      end else begin
        par_err  <= nonempty & top.pe;
        frm_err  <= nonempty & top.fe;
        brk_flag <= nonempty & top.brk;
      end
    end
  end

  p_ovr_when_full_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_err) |-> $past(fifo_full));
  p_rts_low_full_r9: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && $past(rts_auto)) |-> !rts_o);
  p_rdy_with_full_r3: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> rx_rdy);
endmodule

// File: rtl/rx_serial_fifo.sv
module rx_serial_fifo
  import rxq_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              mdrop_en,
  input  logic              blk_err_mode,
  input  logic              rts_auto,
  input  logic              rd_pop,
  input  logic              err_clr,
  output logic [7:0]        rd_data,
  output logic              rx_rdy,
  output logic              fifo_full,
  output logic              ovr_err,
  output logic              par_err,
  output logic              frm_err,
  output logic              brk_flag,
  output logic              addr_flag,
  output logic              brk_delta,
  output logic              rts_o
);
  localparam int CNTW = $clog2(DEPTH+1);
  localparam logic [CNTW-1:0] C_FULL = CNTW'(DEPTH);

  logic            done, brk_evt, accept, space, pop;
  logic            push, pend_v, pend_load, pend_clr, ovr_evt;
  rx_char_t        chr, pend, din, top;
  logic [CNTW-1:0] cnt;

  rx_bit_engine #(.OSR(OSR)) u_eng (
    .clk(clk), .rst(rst), .tick(os_tick), .rxd(rxd), .len_sel(len_sel),
    .par_en(par_en), .par_odd(par_odd), .mdrop_en(mdrop_en),
    .done(done), .chr(chr), .brk_evt(brk_evt)
  );

  assign accept = done && (rx_en || chr.addr);
  assign space  = (cnt != C_FULL);
  assign pop    = rd_pop && (cnt != '0);

  always_comb begin
    push = 1'b0; din = pend; pend_load = 1'b0; pend_clr = 1'b0; ovr_evt = 1'b0;
    if (pend_v && space) begin
      push = 1'b1; pend_clr = 1'b1; pend_load = accept;
    end else if (accept) begin
      if (!pend_v && space) begin
        push = 1'b1; din = chr;
      end else if (!pend_v) pend_load = 1'b1;
      else ovr_evt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0; pend <= '0;
    end else if (pend_load) begin
      pend_v <= 1'b1; pend <= chr;
    end else if (pend_clr) pend_v <= 1'b0;
  end

  rx_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_q (
    .clk(clk), .rst(rst), .push(push), .din(din), .pop(pop),
    .dout(top), .count(cnt)
  );

  rx_flags #(.DEPTH(DEPTH)) u_flg (
    .clk(clk), .rst(rst), .cnt(cnt), .top(top), .push(push), .push_chr(din),
    .ovr_evt(ovr_evt), .brk_evt(brk_evt), .err_clr(err_clr),
    .blk_err_mode(blk_err_mode), .rts_auto(rts_auto),
    .rd_data(rd_data), .rx_rdy(rx_rdy), .fifo_full(fifo_full),
    .ovr_err(ovr_err), .par_err(par_err), .frm_err(frm_err),
    .brk_flag(brk_flag), .addr_flag(addr_flag), .brk_delta(brk_delta),
    .rts_o(rts_o)
  );

  p_slot_only_when_full_r4: assert property (@(posedge clk) disable iff (rst)
    pend_v |-> (cnt == C_FULL) || $past(pop) || $past(pend_load));
  p_drop_when_disabled_r11: assert property (@(posedge clk) disable iff (rst)
    (done && !rx_en && !mdrop_en) |=> $stable(cnt) || $past(pop) || $past(pend_v));
endmodule

// File: tb/tb_rx_serial_fifo.sv
module tb_rx_serial_fifo;
  localparam int BITC = 64;

  logic clk = 1'b0, rst = 1'b1, os_tick = 1'b0, rxd = 1'b1;
  logic rx_en = 1'b1, par_en = 1'b0, par_odd = 1'b0, mdrop_en = 1'b0;
  logic blk_err_mode = 1'b0, rts_auto = 1'b0, rd_pop = 1'b0, err_clr = 1'b0;
  logic [1:0] len_sel = 2'd3;
  logic [7:0] rd_data;
  logic rx_rdy, fifo_full, ovr_err, par_err, frm_err, brk_flag, addr_flag;
  logic brk_delta, rts_o;
  logic [1:0] tdiv = '0;
  int runs = 0, fails = 0, bdel = 0;

  rx_serial_fifo dut (.*);

  always #4 clk = ~clk;
  always @(posedge clk) begin
    tdiv    <= tdiv + 1'b1;
    os_tick <= (tdiv == 2'd3);
  end
  always @(negedge clk) if (brk_delta) bdel++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int nd, input logic [7:0] d, input bit hx,
                      input bit xb, input bit stopv);
    rxd = 1'b0; hold(BITC);
    for (int i = 0; i < nd; i++) begin rxd = d[i]; hold(BITC); end
    if (hx) begin rxd = xb; hold(BITC); end
    rxd = stopv; hold(BITC);
    rxd = 1'b1; hold(8);
  endtask

  task automatic pop1();
    rd_pop = 1'b1; hold(1); rd_pop = 1'b0; hold(4);
  endtask

  task automatic clr();
    err_clr = 1'b1; hold(1); err_clr = 1'b0; hold(4);
  endtask

  task automatic t_reset();
    chk("R12 rdy", rx_rdy, 0); chk("R12 full", fifo_full, 0);
    chk("R12 ovr", ovr_err, 0); chk("R12 rts", rts_o, 1);
    chk("R12 data", rd_data, 0); chk("R12 pe", par_err, 0);
  endtask

  task automatic t_basic();
    send(8, 8'hA5, 0, 0, 1);
    chk("R1 rdy", rx_rdy, 1); chk("R1 data8", rd_data, 8'hA5);
    chk("R6 fe clean", frm_err, 0);
    pop1(); chk("R3 empty after read", rx_rdy, 0);
    pop1(); chk("R3 read empty ignored", rx_rdy, 0);
    len_sel = 2'd0; send(5, 8'h13, 0, 0, 1);
    chk("R1 data5", rd_data, 8'h13); pop1();
    len_sel = 2'd2; send(7, 8'h6B, 0, 0, 1);
    chk("R1 data7", rd_data, 8'h6B); pop1();
    len_sel = 2'd3;
  endtask

  task automatic t_false_start();
    rxd = 1'b0; hold(16); rxd = 1'b1; hold(1200);
    chr_none: chk("R2 no char", rx_rdy, 0);
    send(8, 8'h3C, 0, 0, 1);
    chk("R2 recovers", rd_data, 8'h3C); pop1();
  endtask

  task automatic t_parity();
    par_en = 1'b1; par_odd = 1'b0;
    send(8, 8'h07, 1, 1, 1); chk("R5 even ok", par_err, 0); pop1();
    send(8, 8'h07, 1, 0, 1); chk("R5 even bad", par_err, 1);
    chk("R5 data", rd_data, 8'h07); pop1();
    par_odd = 1'b1;
    send(8, 8'h07, 1, 0, 1); chk("R5 odd ok", par_err, 0); pop1();
    par_en = 1'b0; par_odd = 1'b0;
  endtask

  task automatic t_framing();
    send(8, 8'h81, 0, 0, 0);
    chk("R6 fe", frm_err, 1); chk("R6 not brk", brk_flag, 0);
    chk("R6 data", rd_data, 8'h81); pop1();
  endtask

  task automatic t_err_modes();
    par_en = 1'b1;
    send(8, 8'h01, 1, 0, 1); send(8, 8'h03, 1, 0, 1);
    chk("R7 char top bad", par_err, 1); pop1();
    chk("R7 char top good", par_err, 0); pop1();
    blk_err_mode = 1'b1; clr();
    send(8, 8'h01, 1, 0, 1); send(8, 8'h03, 1, 0, 1);
    pop1(); pop1();
    chk("R7 block sticky", par_err, 1);
    clr(); chk("R7 block cleared", par_err, 0);
    blk_err_mode = 1'b0; par_en = 1'b0;
  endtask

  task automatic t_depth_overrun();
    rts_auto = 1'b1;
    send(8, 8'h01, 0, 0, 1); send(8, 8'h02, 0, 0, 1); send(8, 8'h03, 0, 0, 1);
    chk("R3 full", fifo_full, 1); chk("R9 rts low", rts_o, 0);
    send(8, 8'h04, 0, 0, 1); chk("R4 no ovr at four", ovr_err, 0);
    send(8, 8'h05, 0, 0, 1); chk("R4 ovr", ovr_err, 1);
    for (int k = 1; k <= 4; k++) begin
      chk("R3 order", rd_data, k);
      pop1();
      if (k == 2) chk("R9 rts back", rts_o, 1);
    end
    chk("R4 fifth dropped", rx_rdy, 0);
    clr(); chk("R4 ovr cleared", ovr_err, 0);
    rts_auto = 1'b0;
    send(8, 8'h01, 0, 0, 1); send(8, 8'h02, 0, 0, 1); send(8, 8'h03, 0, 0, 1);
    chk("R9 rts stays high", rts_o, 1);
    pop1(); pop1(); pop1();
  endtask

  task automatic t_break();
    bdel = 0;
    rxd = 1'b0; hold(BITC * 12);
    chk("R8 brk", brk_flag, 1); chk("R8 zero", rd_data, 0);
    chk("R8 one delta", bdel, 1);
    rxd = 1'b1; hold(BITC);
    chk("R8 end delta", bdel, 2); chk("R8 single char", fifo_full, 0);
    pop1(); chk("R8 queue empty", rx_rdy, 0);
  endtask

  task automatic t_multidrop();
    mdrop_en = 1'b1; rx_en = 1'b0;
    send(8, 8'h11, 1, 0, 1); chk("R10 data dropped", rx_rdy, 0);
    send(8, 8'h5A, 1, 1, 1);
    chk("R10 addr kept", rx_rdy, 1); chk("R10 addr flag", addr_flag, 1);
    chk("R10 addr data", rd_data, 8'h5A); pop1();
    rx_en = 1'b1;
    send(8, 8'h22, 1, 0, 1);
    chk("R10 data flag", addr_flag, 0); chk("R10 data", rd_data, 8'h22); pop1();
    mdrop_en = 1'b0; rx_en = 1'b0;
    send(8, 8'h33, 0, 0, 1); chk("R11 dropped", rx_rdy, 0);
    rx_en = 1'b1;
  endtask

  initial begin
    hold(5); rst = 1'b0; hold(4);
    t_reset();
    t_basic();
    t_false_start();
    t_parity();
    t_framing();
    t_err_modes();
    t_depth_overrun();
    t_break();
    t_multidrop();
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule